// File: doc/BRIEF.md
# Glitch-Free Three-Way System Clock Selector

This block picks the system clock from three independent oscillators: a primary source, an internal source and a secondary source. A control agent running on a free-running control clock names a target source and pulses a request. The selector then stops the output clock cleanly, hands the target oscillator an enable, and lets that oscillator count eight of its own rising edges before any of its pulses reach the output. Because each source is gated only while it is low, every high phase on the output is a whole high phase of one source. No shortened pulse can appear, even when the two sources run at very different rates.

While a change is in progress a busy flag is raised and further requests are dropped. Once the new source drives the output, three activity flags show which source is running. A flag for a source is shown only while that source's stability input is high. All flags are clear while busy. If no flag is set, the source in use has not reported stable. After reset the selector brings up the primary source on its own.

Top module: `clk_src_switch`

## Requirements
- R1: After reset, the primary source is enabled without a request. Once its enable is in place, busy falls, `sys_clk` runs at the primary period, and `act_pri` is high while `stable_pri` is high.
- R2: When `busy` is low, a request (`sw_req` high at a rising edge of `ctl_clk`) with a valid `sw_sel` is accepted. `busy` is then high after that edge. Select codes: 2'b00 primary, 2'b01 internal, 2'b10 secondary.
- R3: A request made while `busy` is high is ignored. The source that ends up driving `sys_clk` is the one named by the accepted request.
- R4: A request with `sw_sel` = 2'b11 is ignored. `busy` stays low, and the flags and the `sys_clk` period stay unchanged.
- R5: During a switch, the new source's pulses appear on `sys_clk` only after at least 8 of its own rising edges. So the gap between the last old rising edge and the first new rising edge is at least 8 new-source periods.
- R6: Every high pulse on `sys_clk` lasts exactly one full high phase of one of the sources. No two source enables are ever on together.
- R7: At most one activity flag is set at any time, and all flags are low while `busy` is high.
- R8: The activity flag of the running source is high only while that source's stability input is high. With it low, no flag is set; raising it later sets the flag within a few control cycles.
- R9: After `busy` falls, successive rising edges of `sys_clk` are spaced by the period of the accepted target source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Free-running control clock; requests and flags live here |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_pri | input | 1 | Primary oscillator |
| clk_int | input | 1 | Internal oscillator |
| clk_sec | input | 1 | Secondary oscillator |
| stable_pri | input | 1 | Primary oscillator reports stable |
| stable_int | input | 1 | Internal oscillator reports stable |
| stable_sec | input | 1 | Secondary oscillator reports stable |
| sw_sel | input | 2 | Target source code (00 pri, 01 int, 10 sec, 11 invalid) |
| sw_req | input | 1 | Switch request strobe, sampled on `ctl_clk` |
| sys_clk | output | 1 | Gated system clock |
| busy | output | 1 | Switch in progress |
| act_pri | output | 1 | Primary source running and stable |
| act_int | output | 1 | Internal source running and stable |
| act_sec | output | 1 | Secondary source running and stable |

## Verification
The properties assume that `sw_req` and `sw_sel` are synchronous to `ctl_clk` and change only away from its rising edge. They also assume the stability inputs change slowly compared with the control clock, so the two-stage synchronisers settle before the flags are judged. The bench drives every control input on the falling edge of `ctl_clk` and changes a stability input only between switches. It lets the three oscillators free-run at fixed, unrelated periods, so the source-domain logic sees arbitrary phase relations while the control inputs stay within these assumptions.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  localparam int NUM_SRC = 3;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_PRI = 2'b00,
    SRC_INT = 2'b01,
    SRC_SEC = 2'b10,
    SRC_BAD = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STOP  = 2'd1,
    ST_START = 2'd2
  } ctl_st_e;

  function automatic logic sel_valid(input logic [SEL_W-1:0] s);
    return s != SRC_BAD;
  endfunction

  function automatic logic [NUM_SRC-1:0] src_onehot(input logic [SEL_W-1:0] s);
    logic [NUM_SRC-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (s == SEL_W'(i)) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [NUM_SRC-1:0] act_flags(input logic [SEL_W-1:0] cur,
                                                   input logic [NUM_SRC-1:0] stb,
                                                   input logic               bsy);
    return bsy ? '0 : (src_onehot(cur) & stb);
  endfunction

  function automatic logic edges_done(input int unsigned cnt, input int unsigned lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/clksw_gate.sv
module clksw_gate
  import clksw_pkg::*;
#(
  parameter int EDGES = 8
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic en_req,
  output logic gclk,
  output logic gate_on
);
  localparam int CW = $clog2(EDGES + 1);

  logic          en_s;
  logic [CW-1:0] cnt;
  logic          ready;

  clksw_sync #(.WIDTH(1)) u_en_sync (
    .clk  (src_clk),
    .rst_n(rst_n),
    .d    (en_req),
    .q    (en_s)
  );

  // count own rising edges once the enable has crossed over
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!en_s)
      cnt <= '0;
    else if (!edges_done(int'(cnt), EDGES))
      cnt <= cnt + CW'(1);
  end

  assign ready = en_s && edges_done(int'(cnt), EDGES);

  // enable moves only while the source is low: whole high phases only
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) gate_on <= 1'b0;
    else        gate_on <= ready;
  end

  assign gclk = src_clk & gate_on;
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_SRC-1:0] on_async,
  input  logic [NUM_SRC-1:0] stable_async,
  output logic [NUM_SRC-1:0] en_req,
  output logic               busy,
  output logic [SEL_W-1:0]   cur_sel,
  output logic [SEL_W-1:0]   tgt_sel,
  output logic [NUM_SRC-1:0] act
);
  ctl_st_e            st;
  logic [NUM_SRC-1:0] on_s;
  logic [NUM_SRC-1:0] stb_s;
  logic               accept;
  logic               all_off;
  logic               tgt_on;

  clksw_sync #(.WIDTH(NUM_SRC)) u_on_sync (
    .clk(clk), .rst_n(rst_n), .d(on_async), .q(on_s)
  );

  clksw_sync #(.WIDTH(NUM_SRC)) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .d(stable_async), .q(stb_s)
  );

  assign busy    = (st != ST_IDLE);
  assign accept  = !busy && req && sel_valid(sel);
  assign all_off = (on_s == '0);
  assign tgt_on  = |(on_s & src_onehot(tgt_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_START;
      tgt_sel <= SRC_PRI;
      cur_sel <= SRC_PRI;
      en_req  <= src_onehot(SRC_PRI);
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          tgt_sel <= sel;
          en_req  <= '0;
          st      <= ST_STOP;
        end
        ST_STOP: if (all_off) begin
          en_req <= src_onehot(tgt_sel);
          st     <= ST_START;
        end
        ST_START: if (tgt_on) begin
          cur_sel <= tgt_sel;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign act = act_flags(cur_sel, stb_s, busy);
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import clksw_pkg::*;
#(
  parameter int EDGES = 8
) (
  input  logic       ctl_clk,
  input  logic       rst_n,
  input  logic       clk_pri,
  input  logic       clk_int,
  input  logic       clk_sec,
  input  logic       stable_pri,
  input  logic       stable_int,
  input  logic       stable_sec,
  input  logic [1:0] sw_sel,
  input  logic       sw_req,
  output logic       sys_clk,
  output logic       busy,
  output logic       act_pri,
  output logic       act_int,
  output logic       act_sec
);
  logic [NUM_SRC-1:0] src_clk;
  logic [NUM_SRC-1:0] src_stable;
  logic [NUM_SRC-1:0] gclk;
  logic [NUM_SRC-1:0] gate_on;
  logic [NUM_SRC-1:0] en_req;
  logic [NUM_SRC-1:0] act;
  logic [SEL_W-1:0]   cur_sel;
  logic [SEL_W-1:0]   tgt_sel;

  assign src_clk    = {clk_sec, clk_int, clk_pri};
  assign src_stable = {stable_sec, stable_int, stable_pri};

  clksw_ctrl u_ctrl (
    .clk         (ctl_clk),
    .rst_n       (rst_n),
    .req         (sw_req),
    .sel         (sw_sel),
    .on_async    (gate_on),
    .stable_async(src_stable),
    .en_req      (en_req),
    .busy        (busy),
    .cur_sel     (cur_sel),
    .tgt_sel     (tgt_sel),
    .act         (act)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    clksw_gate #(.EDGES(EDGES)) u_gate (
      .src_clk(src_clk[i]),
      .rst_n  (rst_n),
      .en_req (en_req[i]),
      .gclk   (gclk[i]),
      .gate_on(gate_on[i])
    );
  end

  assign sys_clk = |gclk;
  assign act_pri = act[SRC_PRI];
  assign act_int = act[SRC_INT];
  assign act_sec = act[SRC_SEC];
endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk (
  input logic       ctl_clk,
  input logic       rst_n,
  input logic       sw_req,
  input logic [1:0] sw_sel,
  input logic       busy,
  input logic       act_pri,
  input logic       act_int,
  input logic       act_sec,
  input logic [1:0] tgt_sel,
  input logic [2:0] gate_on
);
  // R2
  accept_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    (!busy && sw_req && sw_sel != 2'b11) |=> busy);

  // R4
  bad_sel_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    (!busy && sw_req && sw_sel == 2'b11) |=> !busy);

  // R3
  busy_hold_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(tgt_sel)));

  // R7
  flag_onehot_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    $onehot0({act_pri, act_int, act_sec}));

  // R7
  busy_quiet_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    busy |-> !(act_pri || act_int || act_sec));

  // R6
  no_overlap_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    $onehot0(gate_on));
endmodule

bind clk_src_switch clk_src_switch_chk u_chk (
  .ctl_clk(ctl_clk),
  .rst_n  (rst_n),
  .sw_req (sw_req),
  .sw_sel (sw_sel),
  .busy   (busy),
  .act_pri(act_pri),
  .act_int(act_int),
  .act_sec(act_sec),
  .tgt_sel(tgt_sel),
  .gate_on(gate_on)
);

// File: tb/clk_src_switch_bench.sv
`timescale 1ns/1ps
module clk_src_switch_bench;
  logic ctl_clk = 0, rst_n = 0;
  logic clk_pri = 0, clk_int = 0, clk_sec = 0;
  logic stable_pri = 1, stable_int = 0, stable_sec = 1;
  logic [1:0] sw_sel = 0;
  logic sw_req = 0;
  logic sys_clk, busy, act_pri, act_int, act_sec;

  int checks = 0, failures = 0, runts = 0;
  realtime last_rise = 0, maxgap = 0;

  always #5  ctl_clk = ~ctl_clk;
  always #7  clk_pri = ~clk_pri;
  always #11 clk_int = ~clk_int;
  always #31 clk_sec = ~clk_sec;

  clk_src_switch u_clk_src_switch (.*);

  function automatic realtime per_of(input int s);
    return (s == 0) ? 14.0 : (s == 1) ? 22.0 : 62.0;
  endfunction

  function automatic logic [2:0] exp_flags(input int s, input logic [2:0] stb);
    logic [2:0] f;
    f = '0;
    f[s] = stb[s];
    return f;
  endfunction

  // R6: every high pulse is a whole source high phase
  always @(posedge sys_clk) begin
    if ($realtime - last_rise > maxgap) maxgap = $realtime - last_rise;
    last_rise = $realtime;
  end
  always @(negedge sys_clk) begin
    realtime w;
    w = $realtime - last_rise;
    if (!((w > 6.99 && w < 7.01) || (w > 10.99 && w < 11.01) || (w > 30.99 && w < 31.01)))
      runts++;
  end

  task automatic chk(input bit ok, input string req, input real act_v, input real exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", req, act_v, exp_v);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3000) begin @(negedge ctl_clk); n++; end
    chk(!busy, "R2 switch completes", real'(busy), 0.0);
  endtask

  task automatic period_chk(input int s, input string req);
    realtime t0, p;
    @(posedge sys_clk); @(posedge sys_clk); t0 = $realtime;
    @(posedge sys_clk); p = $realtime - t0;
    chk(p > per_of(s) - 0.01 && p < per_of(s) + 0.01, req, p, per_of(s));
  endtask

  task automatic flag_chk(input int s, input string req);
    logic [2:0] e, a;
    e = exp_flags(s, {stable_sec, stable_int, stable_pri});
    a = {act_sec, act_int, act_pri};
    chk(a == e, req, real'(a), real'(e));
  endtask

  task automatic request(input logic [1:0] s);
    @(negedge ctl_clk); sw_sel = s; sw_req = 1;
    maxgap = 0;
    @(negedge ctl_clk); sw_req = 0;
  endtask

  task automatic full_switch(input int s, input string tag);
    request(2'(s));
    chk(busy, {tag, " R2 busy after accept"}, real'(busy), 1.0);
    wait_idle();
    @(negedge ctl_clk);
    flag_chk(s, {tag, " R7 flags"});
    period_chk(s, {tag, " R9 period"});
    chk(maxgap >= 8.0 * per_of(s) - 0.01, {tag, " R5 pause"}, maxgap, 8.0 * per_of(s));
  endtask

  initial begin
    #1_500_000;
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cur;
    void'($urandom(32'd4242));
    repeat (4) @(negedge ctl_clk);
    chk(busy && !act_pri && !act_int && !act_sec, "R7 reset state", real'(busy), 1.0);
    rst_n = 1;
    wait_idle();
    @(negedge ctl_clk);
    flag_chk(0, "R1 primary after reset");
    period_chk(0, "R1 primary period");
    cur = 0;

    full_switch(2, "sec");
    cur = 2;

    // R4 invalid code
    request(2'b11);
    chk(!busy, "R4 invalid ignored busy", real'(busy), 0.0);
    flag_chk(cur, "R4 flags unchanged");
    period_chk(cur, "R4 period unchanged");

    // R3 + R8: go to unstable internal, second request while busy
    request(2'b01);
    repeat (2) @(negedge ctl_clk);
    chk(busy, "R3 still busy", real'(busy), 1.0);
    request(2'b00);
    wait_idle();
    @(negedge ctl_clk);
    cur = 1;
    chk(!act_pri && !act_int && !act_sec, "R8 no flag while unstable", real'({act_sec, act_int, act_pri}), 0.0);
    period_chk(1, "R3 first target kept");
    stable_int = 1;
    repeat (5) @(negedge ctl_clk);
    flag_chk(1, "R8 flag after stable");

    // random switching
    for (int k = 0; k < 14; k++) begin
      int s;
      s = int'($urandom % 4);
      if (s == 3) begin
        request(2'b11);
        chk(!busy, "R4 random invalid", real'(busy), 0.0);
        flag_chk(cur, "R4 random flags");
      end else if ($urandom % 3 == 0) begin
        request(2'(s));
        request(2'(($urandom % 3)));
        wait_idle();
        @(negedge ctl_clk);
        cur = s;
        flag_chk(cur, "R3 random busy request");
        period_chk(cur, "R3 random period");
      end else begin
        full_switch(s, "rand");
        cur = s;
      end
    end

    chk(runts == 0, "R6 no runt pulses", real'(runts), 0.0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule